// File: doc/BRIEF.md
# USB Control Transfer Sequencer

This block follows a control transfer on the default endpoint from the device side. It works on packets that are already decoded. A token strobe tells it whether the host sent SETUP, IN or OUT. The bytes of a host data packet arrive one per cycle and are closed by an end strobe. That strobe carries the data PID bit and an error flag, which covers PID, CRC and bit-stuff errors found upstream. For each packet the block chooses the handshake to return, or chooses to stay silent. It also sets the data PID for packets the device sends, and the data PID it expects next from the host.

Each transfer runs through three stages: setup, an optional data stage, and a status stage. The status stage runs in the direction opposite to the data. The 8-byte setup packet is kept in a shadow register. It is copied to the visible setup record only when it is acknowledged. The copy also sets the transfer direction and notes whether the requested length is zero. Local logic feeds in two signals: a busy level, which produces NAK, and a halt level, which produces STALL. Any new SETUP token abandons the transfer in progress and clears an endpoint stall.

Top module: `usb_ctrl_seq`

## Requirements
- R1: After reset the stage is setup (code 0), the expected data PID is DATA0 (0), the setup record is all zeros, and no handshake, transmit or event pulse is active.
- R2: When a setup data packet is DATA0 (pid 0), exactly 8 bytes long, error-free, and arrives while the device is neither busy nor halted, the block does four things. It answers ACK (code 0). It stores byte k in setup_rec bits 8k+7:8k. It pulses setup_new. It moves to the data stage (code 1) with DATA1 expected. Outputs appear in the cycle after the end strobe.
- R3: A setup data packet that has the error flag set, a length other than 8 bytes, or the DATA1 PID gets no handshake. It leaves the setup record and the stage unchanged.
- R4: A valid setup data packet gets NAK (code 1) while busy, and STALL (code 2) while halted. In both cases the setup record is not updated.
- R5: In the data stage, an OUT packet whose PID matches the expected one is ACKed, pulses rx_accept, and inverts the expected PID.
- R6: In the data stage, an OUT packet whose PID does not match is ACKed but does not pulse rx_accept, and the expected PID stays the same.
- R7: In the data stage of a read, an IN token makes the device send data (tx_valid) using the current toggle as its PID. The toggle flips only when host_ack arrives. If no acknowledge comes, the next IN resends with the same PID.
- R8: The status stage (code 2) begins when a token in the direction opposite to the data arrives. A write finishes with IN, and completion is the host's acknowledge. A read finishes with an OUT packet that is ACKed. Completion pulses xfer_done and returns the stage to setup.
- R9: The status stage always uses DATA1. A status IN is sent with PID 1. A status OUT carrying DATA0 is ACKed but does not finish the transfer.
- R10: If bytes 6 and 7 of the setup record are both zero, the block goes straight to the status stage and expects an IN.
- R11: A SETUP token in any stage returns the stage to setup in the next cycle, with DATA0 expected, and clears an earlier stall.
- R12: A token in the wrong direction for the current stage gets STALL. IN and OUT tokens that arrive in the setup stage count as wrong direction. After such a STALL, every IN or OUT is stalled until the next SETUP.
- R13: An OUT packet longer than MAX_PKT bytes gets no handshake and is not accepted.
- R14: In the data stage, busy produces NAK and halt produces STALL. Neither one changes the toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_kind | input | 2 | 0 OUT, 1 IN, 2 SETUP, 3 ignored |
| rx_byte_valid | input | 1 | Host data byte strobe |
| rx_byte | input | 8 | Host data byte |
| rx_end | input | 1 | End of host data packet |
| rx_pid | input | 1 | Data PID of the packet, 0 DATA0, 1 DATA1 |
| rx_err | input | 1 | Packet has a PID, CRC or bit-stuff error |
| host_ack | input | 1 | Host acknowledged the device's data packet |
| dev_busy | input | 1 | Device temporarily unable to take part |
| dev_halt | input | 1 | Device requests host intervention |
| hs_valid | output | 1 | Handshake to send this cycle |
| hs_code | output | 2 | 0 ACK, 1 NAK, 2 STALL |
| tx_valid | output | 1 | Send a data packet now |
| tx_pid | output | 1 | PID of the packet being sent |
| exp_pid | output | 1 | Data PID expected next from the host |
| stage | output | 2 | 0 setup, 1 data, 2 status |
| setup_rec | output | 64 | Last acknowledged setup packet |
| setup_new | output | 1 | Pulses when setup_rec is updated |
| rx_accept | output | 1 | OUT data packet accepted as new data |
| xfer_done | output | 1 | Control transfer finished |

## Verification
The bench builds the block with MAX_PKT set to 8. With that value, the oversize-packet rule is tested by a 9-byte OUT packet, one byte past the limit of 8. The same limit also meets the fixed setup length. The default of 64 would need long byte streams to reach the same boundary. All other behaviour is independent of this parameter, so the smaller value costs no coverage.

// File: rtl/usb_ctrl_seq.sv
module usb_ctrl_seq #(
  parameter int MAX_PKT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tok_valid,
  input  logic [1:0]  tok_kind,
  input  logic        rx_byte_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic        rx_pid,
  input  logic        rx_err,
  input  logic        host_ack,
  input  logic        dev_busy,
  input  logic        dev_halt,
  output logic        hs_valid,
  output logic [1:0]  hs_code,
  output logic        tx_valid,
  output logic        tx_pid,
  output logic        exp_pid,
  output logic [1:0]  stage,
  output logic [63:0] setup_rec,
  output logic        setup_new,
  output logic        rx_accept,
  output logic        xfer_done
);
  localparam int CNT_W = $clog2(MAX_PKT + 2);
  localparam int SETUP_LEN = 8;
  localparam logic [1:0] TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2;
  localparam logic [1:0] HS_ACK = 2'd0, HS_NAK = 2'd1, HS_STALL = 2'd2;
  localparam logic [1:0] ST_SETUP = 2'd0, ST_DATA = 2'd1, ST_STATUS = 2'd2;
  localparam logic [1:0] W_NONE = 2'd0, W_SETUP = 2'd1, W_OUT = 2'd2, W_ACK = 2'd3;

  logic [1:0]       stg, wait_q;
  logic             stat_in, tgl, stall_q;
  logic [CNT_W-1:0] cnt;
  logic [63:0]      shadow;

  logic [1:0] dat_tok, st_tok;
  logic       tok_dat, tok_st, halted, zero_len, pkt_ok;

  assign dat_tok  = stat_in ? TK_OUT : TK_IN;
  assign st_tok   = stat_in ? TK_IN : TK_OUT;
  assign tok_dat  = (stg == ST_DATA) && (tok_kind == dat_tok);
  assign tok_st   = (stg != ST_SETUP) && (tok_kind == st_tok);
  assign halted   = stall_q | dev_halt;
  assign zero_len = (shadow[63:48] == 16'h0000);
  assign pkt_ok   = !rx_err && (cnt <= CNT_W'(MAX_PKT));
  assign exp_pid  = (stg == ST_DATA) ? tgl : (stg == ST_STATUS);
  assign stage    = stg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg <= ST_SETUP;  wait_q <= W_NONE;
      stat_in <= 1'b0;  tgl <= 1'b0;  stall_q <= 1'b0;
      cnt <= '0;  shadow <= '0;  setup_rec <= '0;
      hs_valid <= 1'b0;  hs_code <= HS_ACK;
      tx_valid <= 1'b0;  tx_pid <= 1'b0;
      setup_new <= 1'b0;  rx_accept <= 1'b0;  xfer_done <= 1'b0;
    end else begin
      hs_valid <= 1'b0;  tx_valid <= 1'b0;
      setup_new <= 1'b0;  rx_accept <= 1'b0;  xfer_done <= 1'b0;

      if (tok_valid && tok_kind != 2'd3) begin
        cnt <= '0;
        wait_q <= W_NONE;
        if (tok_kind == TK_SETUP) begin
          stg <= ST_SETUP;
          stall_q <= 1'b0;
          wait_q <= W_SETUP;
        end else if (!tok_dat && !tok_st) begin
          stall_q <= 1'b1;
          if (tok_kind == TK_IN) begin
            hs_valid <= 1'b1;
            hs_code  <= HS_STALL;
          end else begin
            wait_q <= W_OUT;
          end
        end else begin
          if (tok_st) stg <= ST_STATUS;
          if (tok_kind == TK_OUT) begin
            wait_q <= W_OUT;
          end else if (halted) begin
            hs_valid <= 1'b1;
            hs_code  <= HS_STALL;
          end else if (dev_busy) begin
            hs_valid <= 1'b1;
            hs_code  <= HS_NAK;
          end else begin
            tx_valid <= 1'b1;
            tx_pid   <= tok_st ? 1'b1 : tgl;
            wait_q   <= W_ACK;
          end
        end
      end else if (rx_byte_valid) begin
        for (int i = 0; i < SETUP_LEN; i++)
          if (cnt == CNT_W'(i)) shadow[8*i +: 8] <= rx_byte;
        if (cnt <= CNT_W'(MAX_PKT)) cnt <= cnt + 1'b1;
      end else if (rx_end) begin
        cnt <= '0;
        wait_q <= W_NONE;
        if (wait_q == W_SETUP) begin
          if (!rx_err && !rx_pid && cnt == CNT_W'(SETUP_LEN)) begin
            hs_valid <= 1'b1;
            if (halted) hs_code <= HS_STALL;
            else if (dev_busy) hs_code <= HS_NAK;
            else begin
              hs_code   <= HS_ACK;
              setup_rec <= shadow;
              setup_new <= 1'b1;
              tgl       <= 1'b1;
              stat_in   <= zero_len | ~shadow[7];
              stg       <= zero_len ? ST_STATUS : ST_DATA;
            end
          end
        end else if (wait_q == W_OUT && pkt_ok) begin
          hs_valid <= 1'b1;
          if (halted) hs_code <= HS_STALL;
          else if (dev_busy) hs_code <= HS_NAK;
          else begin
            hs_code <= HS_ACK;
            if (rx_pid == exp_pid) begin
              if (stg == ST_STATUS) begin
                xfer_done <= 1'b1;
                stg <= ST_SETUP;
              end else begin
                rx_accept <= 1'b1;
                tgl <= ~tgl;
              end
            end
          end
        end
      end else if (host_ack && wait_q == W_ACK) begin
        wait_q <= W_NONE;
        if (stg == ST_STATUS) begin
          xfer_done <= 1'b1;
          stg <= ST_SETUP;
        end else begin
          tgl <= ~tgl;
        end
      end
    end
  end
endmodule

// File: rtl/usb_ctrl_seq_chk.sv
module usb_ctrl_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hs_valid,
  input logic [1:0]  hs_code,
  input logic        tx_valid,
  input logic        tx_pid,
  input logic        exp_pid,
  input logic [1:0]  stage,
  input logic [63:0] setup_rec,
  input logic        setup_new,
  input logic        rx_accept,
  input logic        xfer_done
);
  a_r2_setup_acked: assert property (@(posedge clk) disable iff (!rst_n)
    setup_new |-> hs_valid && hs_code == 2'd0);
  a_r2_setup_advances: assert property (@(posedge clk) disable iff (!rst_n)
    setup_new |-> stage != 2'd0 && exp_pid);
  a_r3_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    !setup_new |-> $stable(setup_rec));
  a_r5_accept_acked: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept |-> hs_valid && hs_code == 2'd0 && stage == 2'd1);
  a_r7_tx_no_hs: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !hs_valid);
  a_r8_done_to_setup: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> stage == 2'd0 && !rx_accept);
  a_r9_status_data1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && stage == 2'd2 |-> tx_pid);
  a_r10_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    setup_new && setup_rec[63:48] == 16'h0 |-> stage == 2'd2);
  a_r1_stage_legal: assert property (@(posedge clk) disable iff (!rst_n)
    stage != 2'd3);
endmodule

bind usb_ctrl_seq usb_ctrl_seq_chk u_chk (.*);

// File: tb/usb_ctrl_seq_test.sv
`timescale 1ns/1ps
module usb_ctrl_seq_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 0, rx_byte_valid = 0, rx_end = 0, rx_pid = 0, rx_err = 0;
  logic host_ack = 0, dev_busy = 0, dev_halt = 0;
  logic [1:0] tok_kind = 0;
  logic [7:0] rx_byte = 0;
  logic hs_valid, tx_valid, tx_pid, exp_pid, setup_new, rx_accept, xfer_done;
  logic [1:0] hs_code, stage;
  logic [63:0] setup_rec;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  usb_ctrl_seq #(.MAX_PKT(8)) uut (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_hs(input string tag, input logic v, input logic [1:0] code);
    chk({tag, " hs_valid"}, hs_valid, v);
    if (v) chk({tag, " hs_code"}, hs_code, code);
  endtask

  task automatic tok(input logic [1:0] k);
    tok_valid = 1; tok_kind = k;
    @(negedge clk);
    tok_valid = 0;
  endtask

  task automatic pkt(input logic pid, input logic [63:0] d, input int n, input logic err);
    for (int i = 0; i < n; i++) begin
      rx_byte_valid = 1; rx_byte = 8'(d >> (8 * i));
      @(negedge clk);
    end
    rx_byte_valid = 0;
    rx_end = 1; rx_pid = pid; rx_err = err;
    @(negedge clk);
    rx_end = 0; rx_err = 0;
  endtask

  task automatic ack;
    host_ack = 1;
    @(negedge clk);
    host_ack = 0;
  endtask

  function automatic logic [63:0] mk(input logic dir, input logic [15:0] len);
    return {len, 16'h0000, 16'h0100, 8'h06, dir, 7'h00};
  endfunction

  task automatic do_setup(input logic dir, input logic [15:0] len);
    tok(2); pkt(0, mk(dir, len), 8, 0);
  endtask

  task automatic t_reset;
    chk("R1 stage", stage, 0); chk("R1 exp_pid", exp_pid, 0);
    chk("R1 rec", setup_rec, 0); chk("R1 hs", hs_valid, 0);
    chk("R1 tx", tx_valid, 0); chk("R1 pulses", {setup_new, rx_accept, xfer_done}, 0);
  endtask

  task automatic t_setup_bad;
    tok(2); pkt(0, mk(0, 4), 8, 1); chk_hs("R3 err", 0, 0);
    tok(2); pkt(0, mk(0, 4), 7, 0); chk_hs("R3 short", 0, 0);
    tok(2); pkt(1, mk(0, 4), 8, 0); chk_hs("R3 data1", 0, 0);
    chk("R3 rec", setup_rec, 0); chk("R3 stage", stage, 0);
  endtask

  task automatic t_setup_busy_halt;
    dev_busy = 1; tok(2); pkt(0, mk(0, 4), 8, 0); dev_busy = 0;
    chk_hs("R4 busy", 1, 1);
    dev_halt = 1; tok(2); pkt(0, mk(0, 4), 8, 0); dev_halt = 0;
    chk_hs("R4 halt", 1, 2);
    chk("R4 rec", setup_rec, 0); chk("R4 stage", stage, 0);
  endtask

  task automatic t_write;
    tok(2); pkt(0, mk(0, 16), 8, 0);
    chk_hs("R2 ack", 1, 0); chk("R2 new", setup_new, 1);
    chk("R2 rec", setup_rec, mk(0, 16)); chk("R2 stage", stage, 1); chk("R2 exp", exp_pid, 1);
    tok(0); pkt(1, 64'h44332211, 4, 0);
    chk_hs("R5 ack", 1, 0); chk("R5 accept", rx_accept, 1); chk("R5 exp", exp_pid, 0);
    tok(0); pkt(1, 64'h55, 1, 0);
    chk_hs("R6 ack", 1, 0); chk("R6 accept", rx_accept, 0); chk("R6 exp", exp_pid, 0);
    dev_busy = 1; tok(0); pkt(0, 64'h1, 1, 0); dev_busy = 0;
    chk_hs("R14 nak", 1, 1); chk("R14 accept", rx_accept, 0); chk("R14 exp", exp_pid, 0);
    tok(0); pkt(0, 64'h0, 9, 0);
    chk_hs("R13 long", 0, 0); chk("R13 accept", rx_accept, 0); chk("R13 exp", exp_pid, 0);
    tok(0); pkt(0, 64'h0, 8, 0);
    chk_hs("R13 at limit", 1, 0); chk("R13 limit accept", rx_accept, 1); chk("R5 exp2", exp_pid, 1);
    tok(1);
    chk("R8 tx", tx_valid, 1); chk("R9 pid", tx_pid, 1); chk("R8 stage", stage, 2);
    ack;
    chk("R8 done", xfer_done, 1); chk("R8 back", stage, 0);
  endtask

  task automatic t_read;
    do_setup(1, 64); chk("R2 read stage", stage, 1);
    tok(1); chk("R7 tx", tx_valid, 1); chk("R7 pid1", tx_pid, 1);
    tok(1); chk("R7 resend", tx_pid, 1);
    ack; chk("R7 exp after ack", exp_pid, 0);
    tok(1); chk("R7 pid0", tx_pid, 0); ack;
    tok(1); chk("R7 pid1b", tx_pid, 1); ack;
    tok(0); chk("R8 read status", stage, 2); chk("R9 exp", exp_pid, 1);
    pkt(0, 0, 0, 0); chk_hs("R9 d0 ack", 1, 0); chk("R9 d0 no done", xfer_done, 0);
    tok(0); pkt(1, 0, 0, 0);
    chk_hs("R8 status ack", 1, 0); chk("R8 read done", xfer_done, 1); chk("R8 read back", stage, 0);
  endtask

  task automatic t_zero;
    do_setup(0, 0);
    chk("R10 stage", stage, 2); chk("R10 exp", exp_pid, 1);
    tok(0); pkt(1, 0, 0, 0); chk_hs("R10 out stall", 1, 2);
    tok(2); pkt(0, mk(1, 0), 8, 0); chk("R10 read zero stage", stage, 2);
    tok(1); chk("R10 tx", tx_valid, 1); chk("R10 pid", tx_pid, 1);
    ack; chk("R10 done", xfer_done, 1);
  endtask

  task automatic t_wrong;
    do_setup(1, 8); tok(1); ack;
    tok(0); chk("R12 status", stage, 2);
    tok(1); chk_hs("R12 stall", 1, 2); chk("R12 no tx", tx_valid, 0);
    tok(0); pkt(1, 0, 0, 0); chk_hs("R12 sticky", 1, 2); chk("R12 no done", xfer_done, 0);
    tok(2); chk("R11 stage", stage, 0); chk("R11 exp", exp_pid, 0);
    pkt(0, mk(0, 0), 8, 0); chk_hs("R11 cleared", 1, 0);
    tok(1); ack; chk("R11 done", xfer_done, 1);
    tok(1); chk_hs("R12 idle in", 1, 2);
    do_setup(0, 4); chk("R11 pre", stage, 1);
    tok(2); chk("R11 abort", stage, 0); chk("R11 abort exp", exp_pid, 0);
  endtask

  task automatic t_halt_data;
    do_setup(1, 8);
    dev_halt = 1; tok(1); dev_halt = 0;
    chk_hs("R14 stall", 1, 2); chk("R14 no tx", tx_valid, 0); chk("R14 tgl", exp_pid, 1);
    dev_busy = 1; tok(1); dev_busy = 0;
    chk_hs("R14 busy in", 1, 1); chk("R14 tgl2", exp_pid, 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setup_bad;
    t_setup_busy_halt;
    t_write;
    t_read;
    t_zero;
    t_wrong;
    t_halt_data;
    repeat (2) @(negedge clk);
    summary;
  end
endmodule